// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block produces the second ALU operand of a 32-bit RISC data path in a single combinational pass. In register form it shifts a register value by one of four kinds: logical left, logical right, arithmetic right or rotate right. The amount comes from a 5-bit field in the instruction word or from the low byte of another register. In immediate form it rotates an 8-bit constant right by twice a 4-bit field. Each result comes with a shifter carry-out, which the flag logic outside this block may take in place of the ALU carry.

Internally, a decoder folds every encoding and every edge amount into one of six operation kinds, each with an amount clamped to six bits. The six kinds are pass-through, left shift, logical right shift, arithmetic right shift, rotate, and one-bit rotate through carry. A shared shift core then carries out that operation. The immediate form reuses the core's rotate path, so no separate rotator is built. There is no clock and no storage. The output settles within the same cycle as the inputs.

Top module: `opnd_shifter`

## Requirements
- R1: With `use_imm`=1, `opnd_out` equals `imm_val`, zero-extended to 32 bits and rotated right by 2×`rot_fld`. `op_val`, `sh_kind`, `sh_imm` and `amt_reg_lo` have no effect.
- R2: In immediate form, `carry_out` equals `carry_in` when `rot_fld`=0. Otherwise it equals bit 31 of `opnd_out`.
- R3: `sh_kind[2:1]` selects the kind: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. `sh_kind[0]`=0 takes the amount from `sh_imm`, and `sh_kind[0]`=1 takes it from `amt_reg_lo` (0 to 255).
- R4: For amounts 1 to 31, the result is the plain shift or rotate of `op_val`. The carry-out is the last bit moved out: bit 32−n for a left shift, and bit n−1 for the right kinds.
- R5: A left shift by an immediate 0, and any register-specified amount of 0, pass `op_val` through unchanged with `carry_out` = `carry_in`.
- R6: An immediate amount of 0 with logical right or arithmetic right is executed as a shift by 32.
- R7: Rotate with an immediate amount of 0 is a one-bit rotate through carry: `carry_in` enters bit 31 and bit 0 of `op_val` leaves as `carry_out`.
- R8: A left shift by 32 gives 0 with carry equal to bit 0. By more than 32, it gives 0 with carry 0.
- R9: A logical right shift by 32 gives 0 with carry equal to bit 31. By more than 32, it gives 0 with carry 0.
- R10: An arithmetic right shift by 32 or more fills every bit with bit 31 of `op_val`, and the carry equals bit 31.
- R11: A register rotate by a nonzero multiple of 32 returns `op_val` with carry equal to bit 31. Any other amount above 32 acts as a rotate by the amount mod 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| use_imm | input | 1 | Selects the rotated 8-bit immediate form |
| imm_val | input | 8 | Immediate constant |
| rot_fld | input | 4 | Immediate rotate field (amount = 2×field) |
| op_val | input | 32 | Register operand to shift |
| sh_kind | input | 3 | Shift kind and amount source |
| sh_imm | input | 5 | Instruction-encoded shift amount |
| amt_reg_lo | input | 8 | Low byte of the amount register |
| carry_in | input | 1 | Current carry flag |
| opnd_out | output | 32 | Shifted operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The carry-out and the result are formed together, and the carry comes from a different source depending on the amount. It can be a bit of the input, bit 31 of the result, the incoming carry, or a constant 0. An error in either output can therefore hide behind the other. The bench sets up these cases by sweeping each shift kind over amounts 0, 1, 31, 32, 33 and 255, with both carry-in values and with operands whose end bits differ. Both outputs are judged at once against an independent model that moves one bit per step.

// File: rtl/shift_pkg.sv
package shift_pkg;

    // Shift kind carried in sh_kind[2:1]
    typedef enum logic [1:0] {
        ST_LSL = 2'b00,
        ST_LSR = 2'b01,
        ST_ASR = 2'b10,
        ST_ROR = 2'b11
    } shift_type_e;

    // Normalised operation handed to the core
    typedef enum logic [2:0] {
        OPK_PASS,
        OPK_LSL,
        OPK_LSR,
        OPK_ASR,
        OPK_ROR,
        OPK_RRX
    } op_kind_e;

endpackage

// File: rtl/shamt_decode.sv
module shamt_decode
    import shift_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int IMM_AMT_W = 5,
    parameter int REG_AMT_W = 8,
    parameter int ROT_W     = 4,
    parameter int AMT_EFF_W = $clog2(DATA_W) + 1
) (
    input  logic                 use_imm,
    input  logic [ROT_W-1:0]     rot_fld,
    input  logic [2:0]           sh_kind,
    input  logic [IMM_AMT_W-1:0] sh_imm,
    input  logic [REG_AMT_W-1:0] amt_reg_lo,
    output op_kind_e             op_kind,
    output logic [AMT_EFF_W-1:0] amt_eff
);

    localparam int ROT_LOG = $clog2(DATA_W);
    localparam logic [AMT_EFF_W-1:0] AMT_FULL = AMT_EFF_W'(DATA_W);
    localparam logic [AMT_EFF_W-1:0] AMT_OVER = AMT_EFF_W'(DATA_W + 1);

    shift_type_e st;

    always_comb begin
        st      = shift_type_e'(sh_kind[2:1]);
        op_kind = OPK_PASS;
        amt_eff = '0;
        if (use_imm) begin
            // Immediate form: rotate by twice the field
            amt_eff = AMT_EFF_W'({rot_fld, 1'b0});
            op_kind = (rot_fld == '0) ? OPK_PASS : OPK_ROR;
        end else if (sh_kind[0]) begin
            // Register-specified amount, low byte only
            if (amt_reg_lo != '0) begin
                unique case (st)
                    ST_LSL: begin
                        op_kind = OPK_LSL;
                        amt_eff = (int'(amt_reg_lo) > DATA_W) ? AMT_OVER : AMT_EFF_W'(amt_reg_lo);
                    end
                    ST_LSR: begin
                        op_kind = OPK_LSR;
                        amt_eff = (int'(amt_reg_lo) > DATA_W) ? AMT_OVER : AMT_EFF_W'(amt_reg_lo);
                    end
                    ST_ASR: begin
                        op_kind = OPK_ASR;
                        amt_eff = (int'(amt_reg_lo) >= DATA_W) ? AMT_FULL : AMT_EFF_W'(amt_reg_lo);
                    end
                    ST_ROR: begin
                        op_kind = OPK_ROR;
                        amt_eff = (amt_reg_lo[ROT_LOG-1:0] == '0) ? AMT_FULL
                                : AMT_EFF_W'(amt_reg_lo[ROT_LOG-1:0]);
                    end
                    default: op_kind = OPK_PASS;
                endcase
            end
        end else begin
            // Instruction-encoded amount
            if (sh_imm == '0) begin
                unique case (st)
                    ST_LSL: op_kind = OPK_PASS;
                    ST_LSR: begin op_kind = OPK_LSR; amt_eff = AMT_FULL; end
                    ST_ASR: begin op_kind = OPK_ASR; amt_eff = AMT_FULL; end
                    ST_ROR: op_kind = OPK_RRX;
                    default: op_kind = OPK_PASS;
                endcase
            end else begin
                amt_eff = AMT_EFF_W'(sh_imm);
                unique case (st)
                    ST_LSL:  op_kind = OPK_LSL;
                    ST_LSR:  op_kind = OPK_LSR;
                    ST_ASR:  op_kind = OPK_ASR;
                    ST_ROR:  op_kind = OPK_ROR;
                    default: op_kind = OPK_PASS;
                endcase
            end
        end
    end

    // Clamp never exceeds one past the data width
    always_comb begin
        AST_AMT_CLAMPED: assert (int'(amt_eff) <= DATA_W + 1); // R8
    end

endmodule

// File: rtl/shift_core.sv
module shift_core
    import shift_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int AMT_EFF_W = $clog2(DATA_W) + 1
) (
    input  op_kind_e             op_kind,
    input  logic [AMT_EFF_W-1:0] amt_eff,
    input  logic [DATA_W-1:0]    din,
    input  logic                 cin,
    output logic [DATA_W-1:0]    dout,
    output logic                 cout
);

    localparam int ROT_LOG = $clog2(DATA_W);

    logic [DATA_W:0]     left_w;
    logic [DATA_W:0]     right_w;
    logic [DATA_W:0]     arith_w;
    logic [DATA_W-1:0]   rot_w;
    logic [ROT_LOG-1:0]  rot_amt;

    always_comb begin
        rot_amt = amt_eff[ROT_LOG-1:0];
        left_w  = {1'b0, din} << amt_eff;
        right_w = {din, 1'b0} >> amt_eff;
        arith_w = $unsigned($signed({din, 1'b0}) >>> amt_eff);
        rot_w   = (din >> rot_amt) | (din << (DATA_W - int'(rot_amt)));

        unique case (op_kind)
            OPK_LSL: begin dout = left_w[DATA_W-1:0];  cout = left_w[DATA_W]; end
            OPK_LSR: begin dout = right_w[DATA_W:1];   cout = right_w[0];     end
            OPK_ASR: begin dout = arith_w[DATA_W:1];   cout = arith_w[0];     end
            OPK_ROR: begin dout = rot_w;               cout = rot_w[DATA_W-1]; end
            OPK_RRX: begin dout = {cin, din[DATA_W-1:1]}; cout = din[0];      end
            default: begin dout = din;                 cout = cin;            end
        endcase
    end

    // Arithmetic right keeps the sign bit in place for any amount
    always_comb begin
        if (op_kind == OPK_ASR)
            AST_ASR_SIGN_KEPT: assert (dout[DATA_W-1] == din[DATA_W-1]); // R10
    end

endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
    import shift_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int IMM_W     = 8,
    parameter int ROT_W     = 4,
    parameter int IMM_AMT_W = 5,
    parameter int REG_AMT_W = 8
) (
    input  logic                 use_imm,
    input  logic [IMM_W-1:0]     imm_val,
    input  logic [ROT_W-1:0]     rot_fld,
    input  logic [DATA_W-1:0]    op_val,
    input  logic [2:0]           sh_kind,
    input  logic [IMM_AMT_W-1:0] sh_imm,
    input  logic [REG_AMT_W-1:0] amt_reg_lo,
    input  logic                 carry_in,
    output logic [DATA_W-1:0]    opnd_out,
    output logic                 carry_out
);

    localparam int AMT_EFF_W = $clog2(DATA_W) + 1;

    op_kind_e             op_kind;
    logic [AMT_EFF_W-1:0] amt_eff;
    logic [DATA_W-1:0]    core_in;

    assign core_in = use_imm ? DATA_W'(imm_val) : op_val;

    shamt_decode #(
        .DATA_W    (DATA_W),
        .IMM_AMT_W (IMM_AMT_W),
        .REG_AMT_W (REG_AMT_W),
        .ROT_W     (ROT_W),
        .AMT_EFF_W (AMT_EFF_W)
    ) dec_i (
        .use_imm    (use_imm),
        .rot_fld    (rot_fld),
        .sh_kind    (sh_kind),
        .sh_imm     (sh_imm),
        .amt_reg_lo (amt_reg_lo),
        .op_kind    (op_kind),
        .amt_eff    (amt_eff)
    );

    shift_core #(
        .DATA_W    (DATA_W),
        .AMT_EFF_W (AMT_EFF_W)
    ) core_i (
        .op_kind (op_kind),
        .amt_eff (amt_eff),
        .din     (core_in),
        .cin     (carry_in),
        .dout    (opnd_out),
        .cout    (carry_out)
    );

    // Port-level relations spanning decoder and core
    always_comb begin
        if (use_imm && rot_fld == '0)
            AST_IMM_NOROT_CARRY: assert (opnd_out == DATA_W'(imm_val) && carry_out == carry_in); // R2
        if (use_imm && rot_fld != '0)
            AST_IMM_ROT_CARRY: assert (carry_out == opnd_out[DATA_W-1]); // R2
        if (!use_imm && sh_kind[0] && amt_reg_lo == '0)
            AST_REG_ZERO_PASS: assert (opnd_out == op_val && carry_out == carry_in); // R5
        if (!use_imm && sh_kind == 3'b001 && int'(amt_reg_lo) > DATA_W)
            AST_LSL_OVER_ZERO: assert (opnd_out == '0 && !carry_out); // R8
        if (!use_imm && sh_kind == 3'b011 && int'(amt_reg_lo) > DATA_W)
            AST_LSR_OVER_ZERO: assert (opnd_out == '0 && !carry_out); // R9
        if (!use_imm && sh_kind == 3'b101 && int'(amt_reg_lo) >= DATA_W)
            AST_ASR_FILL: assert (opnd_out == {DATA_W{op_val[DATA_W-1]}} && carry_out == op_val[DATA_W-1]); // R10
        if (!use_imm && sh_kind == 3'b111 && amt_reg_lo != '0 && amt_reg_lo[4:0] == '0)
            AST_ROR_WHOLE: assert (opnd_out == op_val && carry_out == op_val[DATA_W-1]); // R11
        if (!use_imm && sh_kind == 3'b110 && sh_imm == '0)
            AST_RRX_CARRY: assert (carry_out == op_val[0] && opnd_out[DATA_W-1] == carry_in); // R7
    end

endmodule

// File: tb/opnd_shifter_tb_top.sv
module opnd_shifter_tb_top;

    logic        clk = 1'b0;
    always #10 clk = ~clk;

    logic        use_imm;
    logic [7:0]  imm_val;
    logic [3:0]  rot_fld;
    logic [31:0] op_val;
    logic [2:0]  sh_kind;
    logic [4:0]  sh_imm;
    logic [7:0]  amt_reg_lo;
    logic        carry_in;
    logic [31:0] opnd_out;
    logic        carry_out;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    opnd_shifter dut_i (
        .use_imm    (use_imm),
        .imm_val    (imm_val),
        .rot_fld    (rot_fld),
        .op_val     (op_val),
        .sh_kind    (sh_kind),
        .sh_imm     (sh_imm),
        .amt_reg_lo (amt_reg_lo),
        .carry_in   (carry_in),
        .opnd_out   (opnd_out),
        .carry_out  (carry_out)
    );

    typedef struct packed {
        logic        ui;
        logic [7:0]  imm;
        logic [3:0]  rot;
        logic [31:0] val;
        logic [2:0]  kind;
        logic [4:0]  shi;
        logic [7:0]  amt;
        logic        ci;
        logic [31:0] eout;
        logic        ec;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 8'hFF, 4'd4, 32'h1234_5678, 3'd0, 5'd0, 8'd0,   1'b0, 32'hFF00_0000, 1'b1, 8'd1},
        '{1'b1, 8'h01, 4'd1, 32'hFFFF_FFFF, 3'd7, 5'd3, 8'd9,   1'b1, 32'h4000_0000, 1'b0, 8'd2},
        '{1'b1, 8'h3C, 4'd0, 32'h0,         3'd0, 5'd0, 8'd0,   1'b1, 32'h0000_003C, 1'b1, 8'd2},
        '{1'b0, 8'h00, 4'd0, 32'hF000_000F, 3'd0, 5'd4, 8'd0,   1'b0, 32'h0000_00F0, 1'b1, 8'd4},
        '{1'b0, 8'h00, 4'd0, 32'h0000_0180, 3'd3, 5'd0, 8'd8,   1'b0, 32'h0000_0001, 1'b1, 8'd3},
        '{1'b0, 8'h00, 4'd0, 32'h8000_0000, 3'd4, 5'd0, 8'd0,   1'b0, 32'hFFFF_FFFF, 1'b1, 8'd6},
        '{1'b0, 8'h00, 4'd0, 32'h0000_0001, 3'd6, 5'd0, 8'd0,   1'b1, 32'h8000_0000, 1'b1, 8'd7},
        '{1'b0, 8'h00, 4'd0, 32'h0000_0003, 3'd1, 5'd0, 8'd32,  1'b0, 32'h0,         1'b1, 8'd8},
        '{1'b0, 8'h00, 4'd0, 32'hFFFF_FFFF, 3'd1, 5'd0, 8'd33,  1'b1, 32'h0,         1'b0, 8'd8},
        '{1'b0, 8'h00, 4'd0, 32'h8000_0000, 3'd3, 5'd0, 8'd32,  1'b0, 32'h0,         1'b1, 8'd9},
        '{1'b0, 8'h00, 4'd0, 32'hFFFF_FFFF, 3'd3, 5'd0, 8'd200, 1'b1, 32'h0,         1'b0, 8'd9},
        '{1'b0, 8'h00, 4'd0, 32'h7FFF_FFFF, 3'd5, 5'd0, 8'd255, 1'b1, 32'h0,         1'b0, 8'd10},
        '{1'b0, 8'h00, 4'd0, 32'h8000_0001, 3'd7, 5'd0, 8'd64,  1'b0, 32'h8000_0001, 1'b1, 8'd11},
        '{1'b0, 8'h00, 4'd0, 32'h0000_001F, 3'd7, 5'd0, 8'd36,  1'b0, 32'hF000_0001, 1'b1, 8'd11},
        '{1'b0, 8'h00, 4'd0, 32'h1234_5678, 3'd3, 5'd9, 8'd0,   1'b1, 32'h1234_5678, 1'b1, 8'd5},
        '{1'b0, 8'h00, 4'd0, 32'hDEAD_BEEF, 3'd0, 5'd0, 8'd7,   1'b0, 32'hDEAD_BEEF, 1'b0, 8'd5},
        '{1'b0, 8'h00, 4'd0, 32'h4000_0000, 3'd2, 5'd0, 8'd0,   1'b1, 32'h0,         1'b0, 8'd6},
        '{1'b0, 8'h00, 4'd0, 32'h8000_0001, 3'd4, 5'd1, 8'd0,   1'b0, 32'hC000_0000, 1'b1, 8'd4}
    };

    localparam int NAMT = 10;
    localparam int AMTS [NAMT] = '{0, 1, 2, 15, 31, 32, 33, 40, 64, 255};

    // Independent model: move one bit per step
    function automatic logic [32:0] model(input logic ui, input logic [7:0] imm,
                                          input logic [3:0] rot, input logic [31:0] val,
                                          input logic [2:0] kind, input logic [4:0] shi,
                                          input logic [7:0] amt, input logic ci);
        logic [31:0] r;
        logic        c;
        int          n;
        int          st;
        c = ci;
        if (ui) begin
            r = {24'h0, imm};
            for (int i = 0; i < 2 * int'(rot); i++) begin
                c = r[0];
                r = {r[0], r[31:1]};
            end
            return {c, r};
        end
        r  = val;
        st = int'(kind[2:1]);
        n  = kind[0] ? int'(amt) : int'(shi);
        if (!kind[0] && shi == 5'd0) begin
            if (st == 1 || st == 2) n = 32;
            if (st == 3) return {val[0], ci, val[31:1]};
        end
        for (int i = 0; i < n; i++) begin
            case (st)
                0: begin c = r[31]; r = r << 1; end
                1: begin c = r[0];  r = r >> 1; end
                2: begin c = r[0];  r = {r[31], r[31:1]}; end
                default: begin c = r[0]; r = {r[0], r[31:1]}; end
            endcase
        end
        return {c, r};
    endfunction

    task automatic apply(input logic ui, input logic [7:0] imm, input logic [3:0] rot,
                         input logic [31:0] val, input logic [2:0] kind, input logic [4:0] shi,
                         input logic [7:0] amt, input logic ci);
        use_imm = ui; imm_val = imm; rot_fld = rot; op_val = val;
        sh_kind = kind; sh_imm = shi; amt_reg_lo = amt; carry_in = ci;
        #5;
    endtask

    task automatic check(input string tag, input logic [31:0] eo, input logic ec);
        n_run++;
        if (opnd_out !== eo || carry_out !== ec) begin
            n_fail++;
            $display("FAIL %s: out=%h c=%b expected out=%h c=%b", tag, opnd_out, carry_out, eo, ec);
        end
    endtask

    function automatic string kind_tag(input logic [2:0] k, input int a);
        if (a == 0) return (k == 3'd2 || k == 3'd4) ? "R6" : (k == 3'd6 ? "R7" : "R5");
        if (a < 32) return "R4";
        case (k[2:1])
            2'd0: return "R8";
            2'd1: return "R9";
            2'd2: return "R10";
            default: return "R11";
        endcase
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                n_run++;
                n_fail++;
                $display("FAIL watchdog: cycles=%0d expected < 100000", cycles);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [32:0] m;
        // Quiet state: all inputs zero gives zero out, zero carry (R5)
        apply(1'b0, 8'h0, 4'h0, 32'h0, 3'd0, 5'd0, 8'd0, 1'b0);
        check("R5 idle", 32'h0, 1'b0);

        // Table of hand-worked vectors
        for (int v = 0; v < NVEC; v++) begin
            apply(VECS[v].ui, VECS[v].imm, VECS[v].rot, VECS[v].val, VECS[v].kind,
                  VECS[v].shi, VECS[v].amt, VECS[v].ci);
            check($sformatf("R%0d vec%0d", VECS[v].req, v), VECS[v].eout, VECS[v].ec);
        end

        // Sweep of every kind, edge amounts, both carries, two operands (R3)
        for (int k = 0; k < 8; k++) begin
            for (int a = 0; a < NAMT; a++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    for (int p = 0; p < 2; p++) begin
                        logic [31:0] val;
                        logic [4:0]  shi;
                        logic [7:0]  amt;
                        val = p ? 32'h5A5A_5A5B : 32'h8000_0001;
                        shi = 5'(AMTS[a] & 31);
                        amt = 8'(AMTS[a]);
                        if (!k[0] && AMTS[a] > 31) continue;
                        apply(1'b0, 8'hA5, 4'h7, val, 3'(k), shi, amt, ci[0]);
                        m = model(1'b0, 8'hA5, 4'h7, val, 3'(k), shi, amt, ci[0]);
                        check($sformatf("%s R3 kind%0d amt%0d", kind_tag(3'(k), AMTS[a]), k, AMTS[a]),
                              m[31:0], m[32]);
                    end
                end
            end
        end

        // Immediate form: every rotate field, both carries (R1, R2)
        for (int r = 0; r < 16; r++) begin
            for (int ci = 0; ci < 2; ci++) begin
                apply(1'b1, 8'h81, 4'(r), 32'hFFFF_FFFF, 3'd5, 5'd17, 8'd40, ci[0]);
                m = model(1'b1, 8'h81, 4'(r), 32'h0, 3'd0, 5'd0, 8'd0, ci[0]);
                check($sformatf("R1 R2 rot%0d", r), m[31:0], m[32]);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule